// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small processor that runs a program held in a sixteen-word instruction store. A control sequencer moves every instruction through a register-transfer fetch: the program counter goes into an address register, the addressed word is captured in a buffer register while the program counter advances, and the buffer is then copied into the instruction register. One execute cycle follows. In that cycle the block decodes the instruction and commits its effects: a register write, a flag update, a branch or a halt.

The datapath has four general registers, a zero flag and a carry flag. The ALU adds, subtracts, increments and clears. Branches can be unconditional or can depend on either flag. A control format loads a register from an external switch word, stops the machine, or does both. Whatever value is written to a register is also presented on a display port, ready for an LED or seven-segment driver. The store is loaded through a simple write port, normally while reset is held. A `done` output shows that the core has halted.

Top module: `mc_core`

## Requirements
- R1: Every instruction takes exactly four clocks: three fetch cycles (address capture, buffer load with program counter increment, instruction register load) and one execute cycle. A program that executes N instructions, the last being a halt, raises `done` on the 4N-th rising edge after reset is released.
- R2: Instructions are 8 bits: op[7:6], cc[5:4], src[3:2], dst[1:0]. Op 00 writes dst+src into dst, and op 01 writes dst−src into dst, both modulo 256.
- R3: Op 10 acts on dst alone: with cc[0]=0 it writes dst+1, and with cc[0]=1 it writes zero.
- R4: Only ops 00, 01 and 10 update the flags. Z is set when the result is zero. C is the carry out of an add or increment, or the borrow of a subtract (src greater than dst), and a clear makes C zero. Branch, load and halt instructions leave both flags unchanged.
- R5: Op 11 with cc 01 always branches, with cc 10 branches when Z is set, and with cc 11 branches when C is set. A taken branch loads the program counter with instr[3:0]. A branch that is not taken continues at the next word.
- R6: Op 11 with cc 00 is the control format 1100 L H dd. L (bit 3) loads register dd from `sw_in`, and H (bit 2) halts. With both set, the load and the halt happen in the same execute cycle.
- R7: `disp_out` takes the value written to any register one cycle after the write and holds it until the next register write.
- R8: Once halted, `done` stays high and no register, flag or display value changes until reset.
- R9: A synchronous active-high reset clears the program counter (execution restarts at word 0), all four registers, both flags, `disp_out` and `done`.
- R10: While `imem_we` is high, the write port stores `imem_wdata` at `imem_waddr`. Fetch then reads that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Instruction store write enable |
| imem_waddr | input | 4 | Instruction store write address |
| imem_wdata | input | 8 | Instruction word to store |
| sw_in | input | 8 | Switch word read by the load form of the control format |
| disp_out | output | 8 | Value most recently written to a register |
| done | output | 1 | High while the core is halted |

## Verification
The switch load and the halt share one execute cycle when the L and H bits are both set. The bench provokes this with a program whose first word is `1100_11dd`. It judges the result at the ports: `disp_out` must show the switch word, and `done` must rise on the fourth edge and stay there with the display unchanged. A second collision is the buffer load and the program counter increment in the same fetch cycle. The checker compares the counter before and after that cycle, and the bench's edge counts would change if either step slipped.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int INSN_W = 8;
    localparam int ADDR_W = 4;
    localparam int IMEM_D = 1 << ADDR_W;
    localparam int NREG   = 4;
    localparam int RSEL_W = $clog2(NREG);

    typedef enum logic [2:0] {
        ST_FA   = 3'd0,   // address capture
        ST_FB   = 3'd1,   // buffer load, counter advance
        ST_FC   = 3'd2,   // instruction register load
        ST_EX   = 3'd3,   // decode and commit
        ST_HALT = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_UNI  = 2'b10,
        OP_CTRL = 2'b11
    } opcode_e;

    typedef struct packed {
        opcode_e             op;
        logic [1:0]          cc;
        logic [RSEL_W-1:0]   src;
        logic [RSEL_W-1:0]   dst;
    } insn_t;

    localparam logic [1:0] CC_SYS    = 2'b00;
    localparam logic [1:0] CC_ALWAYS = 2'b01;
    localparam logic [1:0] CC_ZERO   = 2'b10;
    localparam logic [1:0] CC_CARRY  = 2'b11;

    function automatic logic [ADDR_W-1:0] branch_target(input insn_t i);
        return {i.src, i.dst};
    endfunction

endpackage

// File: rtl/mc_seq.sv
module mc_seq
    import mc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       halt_req,
    output seq_state_e st
);
    seq_state_e st_nx;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_FA:   st_nx = ST_FB;
            ST_FB:   st_nx = ST_FC;
            ST_FC:   st_nx = ST_EX;
            ST_EX:   st_nx = halt_req ? ST_HALT : ST_FA;
            ST_HALT: st_nx = ST_HALT;
            default: st_nx = ST_FA;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_FA;
        else     st <= st_nx;
    end
endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  opcode_e           op,
    input  logic              clr_sel,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res,
    output logic              cout,
    output logic              zero
);
    logic [DATA_W:0] wide;

    always_comb begin
        wide = '0;
        unique case (op)
            OP_ADD:  wide = {1'b0, a} + {1'b0, b};
            OP_SUB:  wide = {1'b0, a} - {1'b0, b};
            OP_UNI:  wide = clr_sel ? '0 : ({1'b0, a} + 1'b1);
            default: wide = '0;
        endcase
        res  = wide[DATA_W-1:0];
        cout = wide[DATA_W];
        zero = (res == '0);
    end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int DATA_W = 8,
    parameter int NREG   = 4,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SEL_W-1:0]  wsel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SEL_W-1:0]  rsel_a,
    input  logic [SEL_W-1:0]  rsel_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (we && (wsel == SEL_W'(g)))
                regs[g] <= wdata;
        end
    end

    assign rdata_a = regs[rsel_a];
    assign rdata_b = regs[rsel_b];
endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              imem_we,
    input  logic [3:0]        imem_waddr,
    input  logic [7:0]        imem_wdata,
    input  logic [DATA_W-1:0] sw_in,
    output logic [DATA_W-1:0] disp_out,
    output logic              done
);
    seq_state_e        st;
    logic [INSN_W-1:0] imem [IMEM_D];
    logic [ADDR_W-1:0] pc, mar;
    logic [INSN_W-1:0] mbr;
    insn_t             ir;
    logic              zf, cf;

    logic [DATA_W-1:0] opa, opb, alu_res, wr_val;
    logic              alu_c, alu_z;
    logic              is_alu, is_sys, is_br, br_go, rf_we, halt_req, in_ex;

    // instruction store write port
    always_ff @(posedge clk) begin
        if (imem_we) imem[imem_waddr] <= imem_wdata;
    end

    // decode during execute
    always_comb begin
        in_ex    = (st == ST_EX);
        is_alu   = (ir.op != OP_CTRL);
        is_sys   = (ir.op == OP_CTRL) && (ir.cc == CC_SYS);
        is_br    = (ir.op == OP_CTRL) && (ir.cc != CC_SYS);
        unique case (ir.cc)
            CC_ALWAYS: br_go = 1'b1;
            CC_ZERO:   br_go = zf;
            CC_CARRY:  br_go = cf;
            default:   br_go = 1'b0;
        endcase
        rf_we    = in_ex && (is_alu || (is_sys && ir.src[1]));
        halt_req = in_ex && is_sys && ir.src[0];
        wr_val   = is_alu ? alu_res : sw_in;
    end

    mc_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .halt_req (halt_req),
        .st       (st)
    );

    mc_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we),
        .wsel    (ir.dst),
        .wdata   (wr_val),
        .rsel_a  (ir.dst),
        .rsel_b  (ir.src),
        .rdata_a (opa),
        .rdata_b (opb)
    );

    mc_alu #(.DATA_W(DATA_W)) u_alu (
        .op      (ir.op),
        .clr_sel (ir.cc[0]),
        .a       (opa),
        .b       (opb),
        .res     (alu_res),
        .cout    (alu_c),
        .zero    (alu_z)
    );

    // fetch register transfers, branch load, flags, display
    always_ff @(posedge clk) begin
        if (rst) begin
            pc       <= '0;
            mar      <= '0;
            mbr      <= '0;
            ir       <= '0;
            zf       <= 1'b0;
            cf       <= 1'b0;
            disp_out <= '0;
        end else begin
            unique case (st)
                ST_FA: mar <= pc;
                ST_FB: begin
                    mbr <= imem[mar];
                    pc  <= pc + 1'b1;
                end
                ST_FC: ir <= insn_t'(mbr);
                ST_EX: begin
                    if (is_br && br_go) pc <= branch_target(ir);
                    if (is_alu) begin
                        zf <= alu_z;
                        cf <= alu_c;
                    end
                end
                default: ;
            endcase
            if (rf_we) disp_out <= wr_val;
        end
    end

    assign done = (st == ST_HALT);
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
    import mc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              done,
    input logic [DATA_W-1:0] disp_out,
    input logic [ADDR_W-1:0] pc,
    input seq_state_e        st,
    input logic              rf_we,
    input insn_t             ir
);
    // R1
    fetch_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FB) |=> (pc == $past(pc) + 1'b1));

    // R1
    fetch_order_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FA) |=> (st == ST_FB));

    // R7
    display_source_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(disp_out) |-> $past(rf_we));

    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (done && $stable(disp_out) && $stable(pc)));

    // R6
    halt_entry_chk: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_EX) && (ir.op == OP_CTRL) && (ir.cc == CC_SYS) && ir.src[0]) |=> done);

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> ((pc == '0) && (disp_out == '0) && !done));
endmodule

bind mc_core mc_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .done     (done),
    .disp_out (disp_out),
    .pc       (pc),
    .st       (st),
    .rf_we    (rf_we),
    .ir       (ir)
);

// File: tb/sim_mc_core.sv
module sim_mc_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       imem_we = 1'b0;
    logic [3:0] imem_waddr = '0;
    logic [7:0] imem_wdata = '0;
    logic [7:0] sw_in = '0;
    logic [7:0] disp_out;
    logic       done;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] prog [16];

    always #10 clk = ~clk;   // 50 MHz

    mc_core u0 (
        .clk        (clk),
        .rst        (rst),
        .imem_we    (imem_we),
        .imem_waddr (imem_waddr),
        .imem_wdata (imem_wdata),
        .sw_in      (sw_in),
        .disp_out   (disp_out),
        .done       (done)
    );

    // {switch, alu word at 2, branch word at 3, expected display}
    // program: 0 load R1, 1 load R2, 2 alu R1,R2, 3 branch to 6, 4 halt, 6 load R3 + halt
    localparam logic [31:0] VEC [8] = '{
        {8'h10, 8'h09, 8'hF6, 8'h20},   // R2 add, no carry -> not taken
        {8'h90, 8'h09, 8'hF6, 8'h90},   // R2 R4 add carry -> taken
        {8'h44, 8'h49, 8'hE6, 8'h44},   // R2 R4 sub to zero -> Z taken
        {8'h44, 8'h49, 8'hF6, 8'h00},   // R4 equal sub, no borrow -> not taken
        {8'hFF, 8'h89, 8'hF6, 8'hFF},   // R3 R4 increment wraps -> carry taken
        {8'h05, 8'h89, 8'hE6, 8'h06},   // R3 increment, nonzero -> not taken
        {8'h33, 8'h99, 8'hE6, 8'h33},   // R3 R4 clear -> Z taken
        {8'h80, 8'h09, 8'hE6, 8'h80}    // R4 add wraps to zero -> Z taken
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic fill_halt();
        for (int i = 0; i < 16; i++) prog[i] = 8'hC4;
    endtask

    task automatic run_prog(input logic [7:0] sw, output int edges);
        @(negedge clk);
        rst   = 1'b1;
        sw_in = sw;
        for (int i = 0; i < 16; i++) begin
            imem_we    = 1'b1;
            imem_waddr = 4'(i);
            imem_wdata = prog[i];
            @(negedge clk);
        end
        imem_we = 1'b0;
        @(negedge clk);
        rst   = 1'b0;
        edges = 0;
        while (!done && edges < 400) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
        end
    endtask

    initial begin
        #3ms;
        n_err++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int e;
        logic [7:0] held;

        // R9 reset state
        repeat (2) @(negedge clk);
        check("R9 reset display", 32'(disp_out), 32'h00);
        check("R9 reset done", 32'(done), 32'h0);

        // table-driven ALU, flag and branch cases (R2 R3 R4 R5 R10)
        for (int v = 0; v < 8; v++) begin
            fill_halt();
            prog[0] = 8'hC9;
            prog[1] = 8'hCA;
            prog[2] = VEC[v][23:16];
            prog[3] = VEC[v][15:8];
            prog[6] = 8'hCF;
            run_prog(VEC[v][31:24], e);
            check($sformatf("R2/R3/R4/R5 vector %0d display", v), 32'(disp_out), 32'(VEC[v][7:0]));
            check($sformatf("R1 vector %0d edges", v), 32'(e), 32'd20);
        end

        // R9: registers and flags cleared by reset (previous run left R2=80, C=1)
        fill_halt();
        prog[0] = 8'hF2;   // branch on carry to 2
        prog[1] = 8'h8A;   // increment R2
        run_prog(8'h00, e);
        check("R9 registers and carry cleared", 32'(disp_out), 32'h01);
        check("R9 restart at word 0 edges", 32'(e), 32'd12);

        // R5 unconditional branch skips word 1
        fill_halt();
        prog[0] = 8'hD3;   // always to 3
        prog[1] = 8'hCC;   // load R0 + halt (must be skipped)
        prog[3] = 8'h80;   // increment R0
        run_prog(8'hAA, e);
        check("R5 always branch display", 32'(disp_out), 32'h01);
        check("R5 always branch edges", 32'(e), 32'd12);

        // R4 loads and branches keep the carry from an earlier add
        fill_halt();
        prog[0] = 8'hC9;
        prog[1] = 8'hCA;
        prog[2] = 8'h09;   // R1 = 0x20, carry set
        prog[3] = 8'hC8;   // load R0 from switch
        prog[4] = 8'hF7;   // branch on carry to 7
        prog[7] = 8'h9B;   // clear R3
        run_prog(8'h90, e);
        check("R4 flag kept across load", 32'(disp_out), 32'h00);
        check("R4 flag kept edges", 32'(e), 32'd28);

        // R6 load and halt in one execute cycle
        fill_halt();
        prog[0] = 8'hCF;
        run_prog(8'h5A, e);
        check("R6 load+halt display", 32'(disp_out), 32'h5A);
        check("R6 load+halt edges", 32'(e), 32'd4);

        // R6 load without halt continues
        fill_halt();
        prog[0] = 8'hC9;
        prog[1] = 8'h89;
        run_prog(8'h3C, e);
        check("R6 load only display", 32'(disp_out), 32'h3D);
        check("R6 load only edges", 32'(e), 32'd12);

        // R6 halt without load leaves display; R8 halted state holds
        fill_halt();
        prog[0] = 8'h8B;
        run_prog(8'h77, e);
        check("R6 halt only display", 32'(disp_out), 32'h01);
        held = disp_out;
        sw_in = 8'hEE;
        repeat (12) @(negedge clk);
        check("R8 done held", 32'(done), 32'h1);
        check("R7 R8 display held", 32'(disp_out), 32'(held));

        // R9 reset from halt
        rst = 1'b1;
        @(negedge clk);
        check("R9 reset from halt done", 32'(done), 32'h0);
        check("R9 reset from halt display", 32'(disp_out), 32'h00);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule